// File: doc/BRIEF.md
# Pager message word serializer

This block sits behind the codeword decoder of a paging receiver. Once an address match has been reported, it marks the receiver as busy with a message and holds the battery-save output HIGH. The decoder then presents codewords one at a time. Each message codeword is packed into a 23-bit host word: the 20 corrected payload bits, the 2-bit correction status code, and an even-parity bit. The block shifts this word out on a serial data line together with a serial clock that it generates itself.

Reception stops when an address codeword arrives, when the idle pattern arrives, or when a break request has been seen. Battery-save then drops and the block waits for the next address match. A sync codeword at a batch boundary does not stop a message that spans batches, and it is not forwarded to the host.

The break request is asynchronous. It is brought into the clock domain through two flip-flops and is acted on only at the next codeword boundary. The decoder spaces codewords at least 23 × 2 × `CLK_HALF` + 2 cycles apart.

Top module: `msg_ser_top`

## Requirements
- R1: After reset `bs_hold`, `ser_clk` and `ser_data` are 0. A pulse on `addr_match` while not receiving sets `bs_hold` to 1 in the cycle after the sampling edge.
- R2: A message codeword becomes the word {payload[19:0], status[1:0], parity}, sent MSB first: payload bit 19 first, parity bit last. The parity bit makes the number of ones in the 23 bits even.
- R3: While no word is being sent, `ser_clk` is 0. Each bit is held on `ser_data` for 2×`CLK_HALF` cycles, with `ser_clk` low for the first `CLK_HALF` cycles and high for the second `CLK_HALF` cycles. A word gives exactly 23 rising edges, and the last one comes `CLK_HALF` + 22×2×`CLK_HALF` cycles after the load edge.
- R4: A codeword of kind 1 (address) during reception ends it. `bs_hold` is 0 one cycle later and nothing is sent.
- R5: A codeword whose raw value equals 32'h7A89C197 ends reception whatever its kind, and nothing is sent. A raw value that differs from it in one bit is handled as its kind says.
- R6: A codeword of kind 2 (sync) during reception is not sent and leaves `bs_hold` at 1. Kinds 0 and 3 are message codewords.
- R7: A break seen while receiving (through a 2-flop synchronizer) is remembered until the next codeword. That codeword is not sent, and `bs_hold` is 0 one cycle later. A break raised while not receiving has no effect on the next reception.
- R8: A codeword presented while not receiving is ignored: nothing is sent and `bs_hold` stays 0.
- R9: After reception ends, a new `addr_match` starts a new reception, and message words are sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_match | input | 1 | One-cycle pulse: own address recognised |
| cw_valid | input | 1 | One-cycle pulse: codeword fields are valid |
| cw_kind | input | 2 | 0 message, 1 address, 2 sync, 3 message |
| cw_raw | input | 32 | Raw received codeword, used for idle detection |
| cw_payload | input | 20 | Corrected message payload |
| cw_status | input | 2 | Correction result code |
| brk_async | input | 1 | Asynchronous break request |
| ser_data | output | 1 | Serial host word, MSB first |
| ser_clk | output | 1 | Serial clock; the host samples on the rising edge |
| bs_hold | output | 1 | HIGH while a message is being received |

## Verification
`bs_hold` reacts one cycle after the edge that samples `addr_match` or `cw_valid`. The bench drives its inputs on falling edges and reads `bs_hold` at the next falling edge.

The first serial rising edge comes `CLK_HALF` cycles after the load edge, and a new one follows every 2×`CLK_HALF` cycles. The bench captures `ser_data` each time it sees a new rising edge of `ser_clk` at a falling edge of `clk`. It waits a full word time plus a margin before it compares the captured bits, the rising-edge count, and the cycle of the last rising edge against values it works out itself.

The break has two synchronizer cycles plus one cycle to be remembered. The bench therefore lets several cycles pass after a break before it presents the next codeword.

// File: rtl/msgser_pkg.sv
package msgser_pkg;
    typedef enum logic [1:0] {
        CW_MSG  = 2'd0,
        CW_ADDR = 2'd1,
        CW_SYNC = 2'd2,
        CW_MSG2 = 2'd3
    } cw_kind_e;

    localparam logic [31:0] IDLE_CW = 32'h7A89C197;
endpackage

// File: rtl/msg_brk_sync.sv
module msg_brk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    output logic brk_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = brk_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign brk_o = q.s2;
endmodule

// File: rtl/msg_word_pack.sv
module msg_word_pack #(
    parameter int DATA_W = 20,
    parameter int STAT_W = 2,
    parameter int CW_W   = 32,
    parameter logic [CW_W-1:0] IDLE_PAT = msgser_pkg::IDLE_CW,
    localparam int WORD_W = DATA_W + STAT_W + 1
) (
    input  logic [CW_W-1:0]   raw_i,
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] payload_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ends_rx_o,
    output logic              is_msg_o
);
    import msgser_pkg::*;

    logic par;
    logic is_idle;
    logic is_addr;
    logic is_sync;

    always_comb begin
        par       = ^{payload_i, status_i};
        word_o    = {payload_i, status_i, par};
        is_idle   = (raw_i == IDLE_PAT);
        is_addr   = (kind_i == CW_ADDR);
        is_sync   = (kind_i == CW_SYNC);
        ends_rx_o = is_idle || is_addr;
        is_msg_o  = !ends_rx_o && !is_sync;
    end
endmodule

// File: rtl/msg_shift_out.sv
module msg_shift_out #(
    parameter int WORD_W   = 23,
    parameter int CLK_HALF = 2,
    localparam int PH_W  = $clog2(2 * CLK_HALF),
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              busy_o
);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * CLK_HALF - 1);
    localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(CLK_HALF);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] sh;
        logic [PH_W-1:0]   ph;
        logic [IDX_W-1:0]  idx;
    } shift_t;

    shift_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.busy = 1'b1;
            d.sh   = word_i;
            d.ph   = '0;
            d.idx  = IDX_TOP;
        end else if (q.busy) begin
            if (q.ph == PH_LAST) begin
                d.ph = '0;
                if (q.idx == '0) begin
                    d.busy = 1'b0;
                    d.sh   = '0;
                end else begin
                    d.idx = q.idx - 1'b1;
                    d.sh  = {q.sh[WORD_W-2:0], 1'b0};
                end
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser_data_o = q.busy & q.sh[WORD_W-1];
    assign ser_clk_o  = q.busy && (q.ph >= PH_RISE);
    assign busy_o     = q.busy;

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !q.busy);                                        // R3
    AST_LOADED_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.busy && !(^q.sh)));                           // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.idx <= IDX_TOP));                             // R3
    AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && !load_i) |=> !ser_clk_o);                       // R3
endmodule

// File: rtl/msg_ser_top.sv
module msg_ser_top #(
    parameter int DATA_W   = 20,
    parameter int STAT_W   = 2,
    parameter int CW_W     = 32,
    parameter int CLK_HALF = 2,
    localparam int WORD_W = DATA_W + STAT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_match,
    input  logic              cw_valid,
    input  logic [1:0]        cw_kind,
    input  logic [CW_W-1:0]   cw_raw,
    input  logic [DATA_W-1:0] cw_payload,
    input  logic [STAT_W-1:0] cw_status,
    input  logic              brk_async,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              bs_hold
);
    import msgser_pkg::*;

    typedef struct packed {
        logic rx;
        logic pend;
    } ctrl_t;

    ctrl_t d, q;

    logic              brk_s;
    logic [WORD_W-1:0] word;
    logic              ends_rx;
    logic              is_msg;
    logic              brk_eff;
    logic              end_ev;
    logic              load;
    logic              sh_busy;

    msg_brk_sync u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .brk_i (brk_async),
        .brk_o (brk_s)
    );

    msg_word_pack #(
        .DATA_W (DATA_W),
        .STAT_W (STAT_W),
        .CW_W   (CW_W)
    ) u_pack (
        .raw_i     (cw_raw),
        .kind_i    (cw_kind),
        .payload_i (cw_payload),
        .status_i  (cw_status),
        .word_o    (word),
        .ends_rx_o (ends_rx),
        .is_msg_o  (is_msg)
    );

    msg_shift_out #(
        .WORD_W   (WORD_W),
        .CLK_HALF (CLK_HALF)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .word_i     (word),
        .ser_data_o (ser_data),
        .ser_clk_o  (ser_clk),
        .busy_o     (sh_busy)
    );

    always_comb begin
        d       = q;
        brk_eff = q.pend || brk_s;
        end_ev  = q.rx && cw_valid && (ends_rx || brk_eff);
        load    = q.rx && cw_valid && is_msg && !brk_eff;
        if (!q.rx) begin
            d.rx   = addr_match;
            d.pend = 1'b0;
        end else begin
            d.rx   = !end_ev;
            d.pend = !end_ev && brk_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bs_hold = q.rx;

    AST_RX_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_hold && addr_match) |=> bs_hold);                      // R1
    AST_END_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_hold && cw_valid && cw_kind == CW_ADDR) |=> !bs_hold);  // R4
    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_hold && cw_valid && cw_raw == IDLE_CW) |=> !bs_hold);   // R5
    AST_SYNC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_hold && cw_valid && cw_kind == CW_SYNC && cw_raw != IDLE_CW
         && !q.pend && !brk_s) |=> (bs_hold && !sh_busy));          // R6
    AST_BRK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_hold && cw_valid && q.pend) |=> (!bs_hold && !sh_busy)); // R7
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!bs_hold && !sh_busy) |=> !sh_busy);                       // R8
endmodule

// File: tb/msg_ser_top_tb.sv
module msg_ser_top_tb;
    localparam int H      = 2;
    localparam int WORD_W = 23;
    localparam int WAIT_C = WORD_W * 2 * H + 4;
    localparam logic [31:0] IDLE = 32'h7A89C197;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_match = 1'b0;
    logic        cw_valid = 1'b0;
    logic [1:0]  cw_kind = 2'd0;
    logic [31:0] cw_raw = 32'h0;
    logic [19:0] cw_payload = 20'h0;
    logic [1:0]  cw_status = 2'd0;
    logic        brk_async = 1'b0;
    logic        ser_data, ser_clk, bs_hold;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rises = 0;
    int last_rise = 0;
    int load_cyc = 0;
    bit done = 0;
    logic prev_clk = 1'b0;
    logic [63:0] cap = '0;

    msg_ser_top #(.CLK_HALF(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_match(addr_match), .cw_valid(cw_valid),
        .cw_kind(cw_kind), .cw_raw(cw_raw), .cw_payload(cw_payload),
        .cw_status(cw_status), .brk_async(brk_async),
        .ser_data(ser_data), .ser_clk(ser_clk), .bs_hold(bs_hold)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ser_clk && !prev_clk) begin
            cap = {cap[62:0], ser_data};
            rises++;
            last_rise = cyc;
        end
        prev_clk = ser_clk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_match();
        @(negedge clk) addr_match = 1'b1;
        @(negedge clk) addr_match = 1'b0;
    endtask

    // presents one codeword and waits a full word time; returns rising edges seen
    task automatic send_cw(input logic [1:0] k, input logic [31:0] raw,
                           input logic [19:0] p, input logic [1:0] s, output int nr);
        int r0;
        r0 = rises;
        @(negedge clk);
        cw_kind = k; cw_raw = raw; cw_payload = p; cw_status = s; cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0;
        load_cyc = cyc;
        repeat (WAIT_C) @(negedge clk);
        nr = rises - r0;
    endtask

    function automatic logic [22:0] expw(input logic [19:0] p, input logic [1:0] s);
        return {p, s, ^{p, s}};
    endfunction

    task automatic msg_word(input logic [1:0] k, input logic [19:0] p, input logic [1:0] s, input string req);
        int nr;
        send_cw(k, {1'b1, p, s, 9'h0}, p, s, nr);
        chk(nr == WORD_W, req, nr, WORD_W);
        chk(cap[22:0] == expw(p, s), req, cap[22:0], expw(p, s));
    endtask

    initial begin
        int nr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bs_hold == 0 && ser_clk == 0 && ser_data == 0, "R1 reset", {bs_hold, ser_clk, ser_data}, 0);

        // R8: codeword while not receiving
        send_cw(2'd0, 32'h8000_1234, 20'hABCDE, 2'd1, nr);
        chk(nr == 0, "R8 no output", nr, 0);
        chk(bs_hold == 0, "R8 bs_hold", bs_hold, 0);

        pulse_match();
        chk(bs_hold == 1, "R1 start", bs_hold, 1);

        // R2/R3 sweep: walking one over payload for every status code
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 20; b++) begin
                msg_word(2'd0, 20'(1) << b, 2'(s), "R2 walk");
            end
            msg_word(2'd3, 20'h00000, 2'(s), "R6 kind3");
            msg_word(2'd0, 20'hFFFFF, 2'(s), "R2 ones");
            msg_word(2'd0, 20'hA5C3F, 2'(s), "R2 mix");
        end
        msg_word(2'd0, 20'h80001, 2'd2, "R3 timing");
        chk(last_rise - load_cyc == H + (WORD_W - 1) * 2 * H, "R3 last edge",
            last_rise - load_cyc, H + (WORD_W - 1) * 2 * H);
        chk(bs_hold == 1, "R2 hold", bs_hold, 1);

        // R6: sync codeword mid-message
        send_cw(2'd2, 32'h7CD215D8, 20'h12345, 2'd0, nr);
        chk(nr == 0 && bs_hold == 1, "R6 sync", {nr[7:0], bs_hold}, 1);
        msg_word(2'd0, 20'h3C3C3, 2'd1, "R6 after sync");

        // R5: near-miss idle values are messages
        for (int j = 0; j < 32; j += 7) begin
            send_cw(2'd0, IDLE ^ (32'h1 << j), 20'h0F0F0, 2'd3, nr);
            chk(nr == WORD_W && cap[22:0] == expw(20'h0F0F0, 2'd3), "R5 near miss", cap[22:0], expw(20'h0F0F0, 2'd3));
        end
        // R5: exact idle ends reception
        send_cw(2'd0, IDLE, 20'h11111, 2'd0, nr);
        chk(nr == 0 && bs_hold == 0, "R5 idle end", {nr[7:0], bs_hold}, 0);

        // R9 restart, then R4 address ends
        pulse_match();
        msg_word(2'd0, 20'h5A5A5, 2'd2, "R9 restart");
        send_cw(2'd1, 32'h0012_3400, 20'h77777, 2'd0, nr);
        chk(nr == 0 && bs_hold == 0, "R4 addr end", {nr[7:0], bs_hold}, 0);

        // R7: break while receiving, released before the codeword
        pulse_match();
        @(negedge clk) brk_async = 1'b1;
        repeat (3) @(negedge clk);
        brk_async = 1'b0;
        repeat (6) @(negedge clk);
        chk(bs_hold == 1, "R7 waits boundary", bs_hold, 1);
        send_cw(2'd0, 32'h8000_0000, 20'h13579, 2'd1, nr);
        chk(nr == 0 && bs_hold == 0, "R7 break end", {nr[7:0], bs_hold}, 0);

        // R7: break while idle has no effect on the next reception
        @(negedge clk) brk_async = 1'b1;
        repeat (3) @(negedge clk);
        brk_async = 1'b0;
        repeat (6) @(negedge clk);
        pulse_match();
        msg_word(2'd0, 20'hFEDCB, 2'd0, "R7 idle break ignored");
        chk(bs_hold == 1, "R7 hold", bs_hold, 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule